// File: doc/BRIEF.md
# Interrupt-Capable General-Purpose Pin Port

This block is one 32-pin general-purpose I/O port with a small memory-mapped register bus. Software sets the value driven on each pin and whether the pin is driven at all. It can also read the pin levels back after they pass through a synchronizer. Every pin can also act as an interrupt source. A pin can be armed for a rising edge, a falling edge, a high level or a low level. Each detected event is held in a sticky status bit, and all enabled status bits are ORed into one port interrupt line.

Each register can be written whole or changed bit by bit through set, clear and invert aliases, so read-modify-write sequences are not needed. Pad cells, pin multiplexing and the interrupt controller that receives the combined line belong to the surrounding chip.

Top module: `gpio_irq_port`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, `pad_out` and `pad_oe` are 0 and `irq` is low.
- R2: Registers sit 0x10 apart: output value 0x00, pin level 0x10, drive enable 0x20, interrupt routing 0x30, interrupt enable 0x40, level-mode select 0x50, polarity select 0x60, status 0x70. A write to offset +0x0 replaces the register. Reads are combinational and return the register at any of its four aliases. Accesses with address bits [1:0] nonzero, or with any address bit above bit 6 set, are ignored and read 0.
- R3: Offsets +0x4, +0x8 and +0xC set, clear and invert each register bit written as 1. Bits written as 0 are left unchanged.
- R4: `pad_out` equals the output value register and `pad_oe` equals the drive enable register (1 = drive, 0 = input).
- R5: The pin level register returns `pad_in` through a two-flop synchronizer: a change becomes readable two clock edges after it is sampled. Writes to it are ignored.
- R6: For each pin, the trigger is selected by {polarity bit, level bit}: 00 falling edge, 01 low level, 10 rising edge, 11 high level. Edges compare the synchronized level with its value one clock earlier. The status bit sets on the clock edge after the synchronized condition holds, that is, three edges after `pad_in` changes.
- R7: A status bit can only set while the pin's routing bit is 1.
- R8: Status bits are sticky and are cleared only by writing 1 through the clear alias (0x78). Writes to 0x70, 0x74 and 0x7C do not change status. A trigger in the same cycle as a clear wins, so in a level mode a clear has no effect while the level persists.
- R9: `irq` is the OR over all pins of (status AND interrupt enable). Clearing an enable bit masks that pin's status without clearing it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_we | input | 1 | Write strobe, one write per cycle while high |
| bus_addr | input | 8 | Byte address of the access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| pad_in | input | 32 | Asynchronous pin levels from the pads |
| pad_out | output | 32 | Value to drive on each pin |
| pad_oe | output | 32 | Per-pin drive enable |
| irq | output | 1 | Combined port interrupt |

## Verification
The four trigger modes are exercised on separate pins. Each sees both the edge that should fire and the one that should not: a rising pulse on a falling-edge pin, and a falling pulse on a rising-edge pin. This separates the polarity decode from the level/edge decode. In the level modes, a status clear while the level persists and another after the level has gone distinguish sticky re-assertion from a one-shot capture. The same edge is applied with routing off and with enable off. This shows that routing gates the capture and enable gates only the output. Two pins pending at once, with one of them cleared, show that the combined line is an OR. The register table walks each alias with both ones and zeros in the data, plus misaligned and out-of-range addresses.

// File: rtl/gpio_port_pkg.sv
// Shared encodings for the interrupt-capable pin port.
// Assumes: register index is address bits [6:4], alias is bits [3:2].
package gpio_port_pkg;

    localparam int NUM_REGS = 8;

    // Register slots; the index is decoded from the address
    typedef enum logic [2:0] {
        REG_DOUT  = 3'd0,
        REG_DIN   = 3'd1,
        REG_OE    = 3'd2,
        REG_ROUTE = 3'd3,
        REG_IEN   = 3'd4,
        REG_LVL   = 3'd5,
        REG_POL   = 3'd6,
        REG_STAT  = 3'd7
    } gpio_reg_e;

    // Write flavours selected by the low address nibble
    typedef enum logic [1:0] {
        ALIAS_WR  = 2'd0,
        ALIAS_SET = 2'd1,
        ALIAS_CLR = 2'd2,
        ALIAS_TOG = 2'd3
    } gpio_alias_e;

endpackage

// File: rtl/gpio_bus_decode.sv
// Address decoder for the port register bus.
// Produces a one-hot write strobe per register slot, the write alias, and
// the read slot. Assumes ADDR_W >= 7; word-misaligned and out-of-range
// addresses decode to nothing.
module gpio_bus_decode
    import gpio_port_pkg::*;
#(
    parameter int ADDR_W = 8
) (
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    output logic [NUM_REGS-1:0] wr_stb,
    output gpio_alias_e         wr_alias,
    output gpio_reg_e           rd_idx,
    output logic                rd_valid
);

    logic upper_ok;

    // Any address bit above the register index must be zero
    generate
        if (ADDR_W > 7) begin : g_upper
            assign upper_ok = ~|bus_addr[ADDR_W-1:7];
        end else begin : g_no_upper
            assign upper_ok = 1'b1;
        end
    endgenerate

    // Slot selection and alignment check
    always_comb begin
        rd_valid = upper_ok && (bus_addr[1:0] == 2'b00);
        rd_idx   = gpio_reg_e'(bus_addr[6:4]);
        wr_alias = gpio_alias_e'(bus_addr[3:2]);
    end

    // One-hot write strobe for the addressed slot
    always_comb begin
        wr_stb = '0;
        if (bus_we && rd_valid) begin
            wr_stb = NUM_REGS'(1) << bus_addr[6:4];
        end
    end

endmodule

// File: rtl/gpio_alias_reg.sv
// One control register with write, set, clear and invert aliases.
// Assumes at most one write per cycle; resets to zero.
module gpio_alias_reg
    import gpio_port_pkg::*;
#(
    parameter int W = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  gpio_alias_e alias_op,
    input  logic [W-1:0] wdata,
    output logic [W-1:0] q
);

    // Apply the selected alias to the stored bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q <= '0;
        end else if (wr_en) begin
            case (alias_op)
                ALIAS_WR:  q <= wdata;
                ALIAS_SET: q <= q | wdata;
                ALIAS_CLR: q <= q & ~wdata;
                ALIAS_TOG: q <= q ^ wdata;
                default:   q <= q;
            endcase
        end
    end

endmodule

// File: rtl/gpio_in_sync.sv
// Multi-flop synchronizer for the pad inputs plus a one-cycle history
// register used for edge detection. Assumes each pin is independent
// (no bus coherence is needed across pins).
module gpio_in_sync #(
    parameter int W      = 32,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] pad_in,
    output logic [W-1:0] sync_q,
    output logic [W-1:0] prev_q
);

    logic [W-1:0] stage_q [STAGES];

    // Shift the pad levels through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < STAGES; i++) begin
                stage_q[i] <= '0;
            end
        end else begin
            stage_q[0] <= pad_in;
            for (int i = 1; i < STAGES; i++) begin
                stage_q[i] <= stage_q[i-1];
            end
        end
    end

    assign sync_q = stage_q[STAGES-1];

    // Remember the previous synchronized level for edge compare
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev_q <= '0;
        end else begin
            prev_q <= sync_q;
        end
    end

endmodule

// File: rtl/gpio_irq_detect.sv
// Per-pin trigger detection, sticky status and the combined interrupt.
// Mode per pin is {pol, lvl}: 00 fall, 01 low, 10 rise, 11 high.
// A new trigger wins over a clear in the same cycle.
module gpio_irq_detect #(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] lvl,
    input  logic [W-1:0] pol,
    input  logic [W-1:0] route,
    input  logic [W-1:0] en,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] prev,
    input  logic [W-1:0] clr_mask,
    output logic [W-1:0] stat_q,
    output logic         irq
);

    logic [W-1:0] hit;

    // Per-pin trigger decode from the two mode bits
    generate
        for (genvar p = 0; p < W; p++) begin : g_pin
            always_comb begin
                case ({pol[p], lvl[p]})
                    2'b00:   hit[p] = prev[p] & ~cur[p];
                    2'b01:   hit[p] = ~cur[p];
                    2'b10:   hit[p] = cur[p] & ~prev[p];
                    default: hit[p] = cur[p];
                endcase
            end
        end
    endgenerate

    // Sticky status: routed triggers set, clear alias clears, set wins
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stat_q <= '0;
        end else begin
            stat_q <= (stat_q & ~clr_mask) | (hit & route);
        end
    end

    // Combined port interrupt
    assign irq = |(stat_q & en);

endmodule

// File: rtl/gpio_irq_port.sv
// Top of the 32-pin port: bus decode, alias registers, input
// synchronizer, interrupt detection and the read mux.
// Assumes a single-cycle write bus and a combinational read.
module gpio_irq_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 32,
    parameter int ADDR_W      = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pad_in,
    output logic [NPINS-1:0]  pad_out,
    output logic [NPINS-1:0]  pad_oe,
    output logic              irq
);

    logic [NUM_REGS-1:0] wr_stb;
    gpio_alias_e         wr_alias;
    gpio_reg_e           rd_idx;
    logic                rd_valid;
    logic [NPINS-1:0]    ctrl_q [NUM_REGS];
    logic [NPINS-1:0]    sync_q;
    logic [NPINS-1:0]    prev_q;
    logic [NPINS-1:0]    stat_q;
    logic [NPINS-1:0]    clr_mask;
    logic [NPINS-1:0]    route_q;
    logic [NPINS-1:0]    en_q;

    gpio_bus_decode #(.ADDR_W(ADDR_W)) u_dec (
        .bus_we   (bus_we),
        .bus_addr (bus_addr),
        .wr_stb   (wr_stb),
        .wr_alias (wr_alias),
        .rd_idx   (rd_idx),
        .rd_valid (rd_valid)
    );

    // Writable control registers; input and status slots have other logic
    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            if (g == int'(REG_DIN) || g == int'(REG_STAT)) begin : g_none
                assign ctrl_q[g] = '0;
            end else begin : g_ctrl
                gpio_alias_reg #(.W(NPINS)) u_reg (
                    .clk      (clk),
                    .rst_n    (rst_n),
                    .wr_en    (wr_stb[g]),
                    .alias_op (wr_alias),
                    .wdata    (bus_wdata),
                    .q        (ctrl_q[g])
                );
            end
        end
    endgenerate

    assign route_q = ctrl_q[REG_ROUTE];
    assign en_q    = ctrl_q[REG_IEN];
    assign pad_out = ctrl_q[REG_DOUT];
    assign pad_oe  = ctrl_q[REG_OE];

    gpio_in_sync #(.W(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pad_in (pad_in),
        .sync_q (sync_q),
        .prev_q (prev_q)
    );

    // Status clears come only from the clear alias of the status slot
    always_comb begin
        clr_mask = '0;
        if (wr_stb[REG_STAT] && wr_alias == ALIAS_CLR) begin
            clr_mask = bus_wdata;
        end
    end

    gpio_irq_detect #(.W(NPINS)) u_det (
        .clk      (clk),
        .rst_n    (rst_n),
        .lvl      (ctrl_q[REG_LVL]),
        .pol      (ctrl_q[REG_POL]),
        .route    (route_q),
        .en       (en_q),
        .cur      (sync_q),
        .prev     (prev_q),
        .clr_mask (clr_mask),
        .stat_q   (stat_q),
        .irq      (irq)
    );

    // Read mux over all register slots
    always_comb begin
        bus_rdata = '0;
        if (rd_valid) begin
            case (rd_idx)
                REG_DIN:  bus_rdata = sync_q;
                REG_STAT: bus_rdata = stat_q;
                default:  bus_rdata = ctrl_q[rd_idx];
            endcase
        end
    end

endmodule

// File: rtl/gpio_irq_port_chk.sv
// Assertion checker for gpio_irq_port, bound to every instance.
// Assumes the default register map (status clear alias at 0x78).
module gpio_irq_port_chk #(
    parameter int NPINS  = 32,
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [NPINS-1:0]  bus_wdata,
    input logic [NPINS-1:0]  pad_out,
    input logic              irq,
    input logic [NPINS-1:0]  stat_q,
    input logic [NPINS-1:0]  route_q,
    input logic [NPINS-1:0]  en_q
);

    localparam logic [ADDR_W-1:0] STAT_CLR_ADDR = ADDR_W'(8'h78);
    localparam logic [ADDR_W-1:0] DOUT_ADDR     = '0;

    logic [NPINS-1:0] clr_seen;

    // Clear request as seen from the bus
    assign clr_seen = (bus_we && bus_addr == STAT_CLR_ADDR) ? bus_wdata : '0;

    // R1: reset leaves status, routing, enable and output value at zero
    p_reset_clears_r1: assert property (@(posedge clk)
        !rst_n |=> (stat_q == '0 && route_q == '0 && en_q == '0 && pad_out == '0));

    // R2: a base write to the output slot appears on the pins next cycle
    p_dout_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_we && bus_addr == DOUT_ADDR) |=> (pad_out == $past(bus_wdata)));

    // R7: newly set status bits were routed in the previous cycle
    p_new_stat_routed_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> ((stat_q & ~$past(stat_q) & ~$past(route_q)) == '0));

    // R8: a status bit only drops after a clear-alias write of that bit
    p_stat_sticky_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> (($past(stat_q) & ~$past(clr_seen) & ~stat_q) == '0));

    // R9: with every enable cleared the combined line stays low
    p_irq_masked_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (en_q == '0) |-> !irq);

endmodule

bind gpio_irq_port gpio_irq_port_chk #(.NPINS(NPINS), .ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .pad_out   (pad_out),
    .irq       (irq),
    .stat_q    (stat_q),
    .route_q   (route_q),
    .en_q      (en_q)
);

// File: tb/gpio_irq_port_bench.sv
`timescale 1ns/1ps
module gpio_irq_port_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [31:0] pad_in = '0;
    logic [31:0] pad_out;
    logic [31:0] pad_oe;
    logic        irq;

    int n_tests = 0;
    int n_fail  = 0;
    bit finished = 1'b0;
    logic [31:0] rd;

    always #2 clk = ~clk;

    gpio_irq_port u_gpio_irq_port (
        .clk       (clk),
        .rst_n     (rst_n),
        .bus_we    (bus_we),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .pad_in    (pad_in),
        .pad_out   (pad_out),
        .pad_oe    (pad_oe),
        .irq       (irq)
    );

    // {write addr, write data, read addr, expected read}
    localparam int NVEC = 14;
    localparam logic [79:0] VEC [NVEC] = '{
        {8'h00, 32'hA5A5_0F0F, 8'h00, 32'hA5A5_0F0F},  // R2 base write
        {8'h04, 32'h0000_00F0, 8'h00, 32'hA5A5_0FFF},  // R3 set
        {8'h08, 32'hA500_0000, 8'h00, 32'h00A5_0FFF},  // R3 clear
        {8'h0C, 32'hFFFF_0000, 8'h00, 32'hFF5A_0FFF},  // R3 invert
        {8'h0C, 32'h0000_0000, 8'h00, 32'hFF5A_0FFF},  // R3 zero data no change
        {8'h20, 32'h0000_FFFF, 8'h20, 32'h0000_FFFF},  // R2 base write
        {8'h28, 32'h0000_00FF, 8'h24, 32'h0000_FF00},  // R3 clear, read via alias
        {8'h21, 32'hFFFF_FFFF, 8'h20, 32'h0000_FF00},  // R2 misaligned ignored
        {8'h54, 32'h0000_0003, 8'h50, 32'h0000_0003},  // R3 set
        {8'h58, 32'h0000_0001, 8'h5C, 32'h0000_0002},  // R3 clear
        {8'h10, 32'hFFFF_FFFF, 8'h10, 32'h0000_0000},  // R5 input slot read-only
        {8'h70, 32'hFFFF_FFFF, 8'h70, 32'h0000_0000},  // R8 base write ignored
        {8'h74, 32'hFFFF_FFFF, 8'h70, 32'h0000_0000},  // R8 set alias ignored
        {8'h80, 32'hFFFF_FFFF, 8'h80, 32'h0000_0000}   // R2 out of range
    };

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic do_write(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_we    = 1'b1;
        bus_addr  = a;
        bus_wdata = d;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic do_read(input logic [7:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #0.5;
        d = bus_rdata;
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    // Watchdog: a hung run counts as a failure and still reports
    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

    initial begin
        wait_n(4);
        rst_n = 1'b1;

        // R1: reset state of every slot and port
        for (int r = 0; r < 8; r++) begin
            do_read(8'(r * 16), rd);
            check("R1 register reset", rd, 32'h0);
        end
        check("R1 pad_out reset", pad_out, 32'h0);
        check("R1 pad_oe reset", pad_oe, 32'h0);
        check("R1 irq reset", {31'h0, irq}, 32'h0);

        // Table walk: register map and alias behaviour (R2 R3 R5 R8)
        for (int i = 0; i < NVEC; i++) begin
            do_write(VEC[i][79:72], VEC[i][71:40]);
            do_read(VEC[i][39:32], rd);
            check($sformatf("R2/R3 table vector %0d", i), rd, VEC[i][31:0]);
        end

        // R4: pins follow the output value and drive enable registers
        check("R4 pad_out", pad_out, 32'hFF5A_0FFF);
        check("R4 pad_oe", pad_oe, 32'h0000_FF00);
        do_write(8'h00, 32'h0);
        do_write(8'h20, 32'h0);
        do_write(8'h50, 32'h0);

        // R5: two-edge synchronizer latency
        @(negedge clk);
        pad_in   = 32'hDEAD_BEEF;
        bus_addr = 8'h10;
        @(negedge clk);
        check("R5 one edge not yet visible", bus_rdata, 32'h0);
        @(negedge clk);
        check("R5 visible after two edges", bus_rdata, 32'hDEAD_BEEF);
        pad_in = 32'h0;
        wait_n(4);

        // R6: rising edge on pin 3, three edges from pad to irq
        do_write(8'h64, 32'h8);
        do_write(8'h34, 32'h8);
        do_write(8'h44, 32'h8);
        @(negedge clk);
        pad_in = 32'h8;
        wait_n(2);
        check("R6 rising not yet captured", {31'h0, irq}, 32'h0);
        wait_n(1);
        check("R6 rising irq", {31'h0, irq}, 32'h1);
        do_read(8'h70, rd);
        check("R6 rising status", rd, 32'h8);
        // R8: edge clear sticks while level stays high
        do_write(8'h78, 32'h8);
        wait_n(2);
        do_read(8'h70, rd);
        check("R8 edge status cleared", rd, 32'h0);
        check("R8 irq drops after clear", {31'h0, irq}, 32'h0);

        // R9: enable off masks the line but status is captured
        pad_in = 32'h0;
        wait_n(4);
        do_write(8'h48, 32'h8);
        pad_in = 32'h8;
        wait_n(4);
        check("R9 masked irq", {31'h0, irq}, 32'h0);
        do_read(8'h70, rd);
        check("R9 masked status kept", rd, 32'h8);
        do_write(8'h44, 32'h8);
        check("R9 unmask raises irq", {31'h0, irq}, 32'h1);
        do_write(8'h78, 32'h8);
        do_write(8'h38, 32'h8);
        do_write(8'h48, 32'h8);
        pad_in = 32'h0;
        wait_n(4);

        // R6: falling edge mode on pin 5 ignores the rising edge
        do_write(8'h34, 32'h20);
        do_write(8'h44, 32'h20);
        pad_in = 32'h20;
        wait_n(4);
        do_read(8'h70, rd);
        check("R6 falling mode ignores rise", rd, 32'h0);
        pad_in = 32'h0;
        wait_n(4);
        do_read(8'h70, rd);
        check("R6 falling captured", rd, 32'h20);
        check("R9 falling irq", {31'h0, irq}, 32'h1);
        do_write(8'h78, 32'h20);
        do_write(8'h38, 32'h20);
        do_write(8'h48, 32'h20);

        // R6/R8: high level on pin 7 re-asserts through a clear
        do_write(8'h54, 32'h80);
        do_write(8'h64, 32'h80);
        do_write(8'h34, 32'h80);
        do_write(8'h44, 32'h80);
        pad_in = 32'h80;
        wait_n(4);
        do_read(8'h70, rd);
        check("R6 high level captured", rd, 32'h80);
        do_write(8'h78, 32'h80);
        do_read(8'h70, rd);
        check("R8 level clear has no effect", rd, 32'h80);
        pad_in = 32'h0;
        wait_n(4);
        do_write(8'h78, 32'h80);
        do_read(8'h70, rd);
        check("R8 level clear after release", rd, 32'h0);
        check("R9 irq low after release", {31'h0, irq}, 32'h0);
        do_write(8'h38, 32'h80);
        do_write(8'h48, 32'h80);

        // R6: low level on pin 9 fires as soon as it is routed
        do_write(8'h54, 32'h200);
        do_write(8'h34, 32'h200);
        wait_n(2);
        do_read(8'h70, rd);
        check("R6 low level captured", rd, 32'h200);
        pad_in = 32'h200;
        wait_n(4);
        do_write(8'h78, 32'h200);
        do_read(8'h70, rd);
        check("R6 low level released", rd, 32'h0);
        do_write(8'h38, 32'h200);
        pad_in = 32'h0;
        wait_n(4);

        // R7: unrouted pin 12 does not capture
        do_write(8'h64, 32'h0000_1000);
        do_write(8'h44, 32'h0000_1000);
        pad_in = 32'h0000_1000;
        wait_n(4);
        do_read(8'h70, rd);
        check("R7 unrouted no status", rd, 32'h0);
        check("R7 unrouted no irq", {31'h0, irq}, 32'h0);
        do_write(8'h34, 32'h0000_1000);
        pad_in = 32'h0;
        wait_n(4);
        pad_in = 32'h0000_1000;
        wait_n(4);
        do_read(8'h70, rd);
        check("R7 routed captures", rd, 32'h0000_1000);

        // R9: two pins pending, OR of enabled status
        do_write(8'h64, 32'h0010_0000);
        do_write(8'h34, 32'h0010_0000);
        do_write(8'h44, 32'h0010_0000);
        pad_in = 32'h0010_1000;
        wait_n(4);
        do_read(8'h70, rd);
        check("R9 two pins pending", rd, 32'h0010_1000);
        do_write(8'h78, 32'h0000_1000);
        do_read(8'h70, rd);
        check("R8 selective clear", rd, 32'h0010_0000);
        check("R9 other pin keeps irq", {31'h0, irq}, 32'h1);
        do_write(8'h48, 32'h0010_0000);
        check("R9 masking last pin drops irq", {31'h0, irq}, 32'h0);

        finished = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule